// File: doc/BRIEF.md
# Reset Boot Release Sequencer

This block decides when a processor core may leave reset and how it gets there. After the chip-level reset is released, the rest of the device runs while the core stays stalled. The sequencer then releases the core in one of three ways, chosen by boot straps. An external host can load memory and then set a start flag. A debug agent can arm a breakpoint at the first instruction and then release the core. Or the sequencer can copy a 1 KB boot image from an external ROM window into internal memory at address 0 on its own, then release the core.

The active-low reset input is asserted asynchronously. An internal reset is released from it synchronously. The straps are taken as they stand when that internal reset is released, and are then frozen. In ROM boot the block reads the ROM one beat at a time, 8 or 16 bits wide. It packs the beats into 32-bit words in the chosen byte order and writes 256 words through the internal memory write port. Host memory writes pass through that same port whenever no copy is running.

Top module: `boot_release_ctrl`

## Requirements
- R1: While `rst_n` is low, and until the internal reset is released two clock edges after `rst_n` rises, the outputs are held as follows: `core_stall`=1, `mem_we`=0, `rom_rd_en`=0, `rom_done`=0, `start_flag`=0, `core_irq`=0 and `bkpt_armed`=0.
- R2: The straps are captured at the release of the internal reset and ignored after that. The `strap_boot_mode` codes are 2'b00 host, 2'b11 host, 2'b01 debug, 2'b10 ROM. `strap_rom16`=1 selects 16-bit ROM beats. `strap_big_end`=1 selects big-endian packing.
- R3: In host mode the core stays stalled until the host writes the start bit with `host_ctl_we`=1 and `host_ctl_start`=1. One edge after that write, `core_stall`=0 and `start_flag`=1, and `core_start_addr` reads 0. Start writes made while the internal reset is asserted are ignored.
- R4: The start write that releases the core raises no `core_irq`. While the core runs in host or debug mode, a start write with `start_flag`=0 sets the flag and gives a one-cycle `core_irq` pulse one edge later. A start write while the flag is 1 gives no pulse. `core_clr_start` clears the flag.
- R5: `dbg_release` has no effect outside debug mode. In debug mode a host start write sets `start_flag` but does not release the core. A `dbg_release` pulse sets `bkpt_armed` one edge later while the core is still stalled. One further edge later `core_stall`=0 and `start_flag`=1, whether or not the host had already set the flag.
- R6: In ROM mode the block writes exactly 256 words, at byte addresses 0x000, 0x004, … 0x3FC in ascending order. The words are read from `ROM_BASE` onward.
- R7: With 8-bit beats, each word is built from 4 consecutive ROM bytes. In little-endian order the lowest-addressed byte goes to bits 7:0; in big-endian order it goes to bits 31:24.
- R8: With 16-bit beats, each word is built from 2 half-words. In little-endian order the first half-word goes to bits 15:0; in big-endian order it goes to bits 31:16. The ROM returns each half-word already in system byte order.
- R9: `rom_done` is 1 exactly in the cycle that writes address 0x3FC, while `core_stall` is still 1. `core_stall` is 0 from the following cycle on.
- R10: In ROM mode, host start writes and `dbg_release` are ignored both during and after the copy: `start_flag`, `bkpt_armed` and `core_irq` stay 0.
- R11: When no copy is running, a host memory write appears on `mem_we`/`mem_addr`/`mem_wdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| strap_boot_mode | input | 2 | Boot method strap |
| strap_rom16 | input | 1 | ROM beat width strap (1 = 16 bits) |
| strap_big_end | input | 1 | Packing order strap (1 = big-endian) |
| host_ctl_we | input | 1 | Host control register write strobe |
| host_ctl_start | input | 1 | Start bit value in a host control write |
| host_mem_we | input | 1 | Host memory write strobe |
| host_mem_addr | input | MEM_AW | Host memory byte address |
| host_mem_wdata | input | MEM_DW | Host memory write data |
| dbg_release | input | 1 | Debug agent release request |
| core_clr_start | input | 1 | Core clears the start flag |
| rom_rd_en | output | 1 | ROM read request, one cycle |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_rvalid | input | 1 | ROM read data valid |
| rom_rdata | input | ROM_DW | ROM read data (8-bit beats use bits 7:0) |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | MEM_AW | Internal memory byte address |
| mem_wdata | output | MEM_DW | Internal memory write data |
| core_stall | output | 1 | Core held stalled |
| core_start_addr | output | PC_W | Core fetch address on release |
| core_irq | output | 1 | Start interrupt pulse to the running core |
| start_flag | output | 1 | Start bit of the host control register |
| bkpt_armed | output | 1 | Breakpoint at address 0 armed |
| rom_done | output | 1 | Last copy word written |

## Verification
The properties assume that the ROM answers each read request with exactly one `rom_rvalid`, and only while a read is outstanding. They also assume the straps do not change during the two edges in which the internal reset is released. The bench ROM model replies one cycle after each `rom_rd_en` and never on its own. The straps are set before `rst_n` rises and changed only after the release has settled. The bench never asserts `core_clr_start` in the same cycle as a host start write, so clear and set never meet.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    MODE_HOST     = 2'b00,
    MODE_DEBUG    = 2'b01,
    MODE_ROM      = 2'b10,
    MODE_HOST_ALT = 2'b11
  } boot_mode_e;

  typedef struct packed {
    boot_mode_e mode;
    logic       rom16;
    logic       big_end;
  } strap_t;

  typedef enum logic [2:0] {
    SEQ_HOLD,
    SEQ_HOST_WAIT,
    SEQ_DBG_WAIT,
    SEQ_DBG_ARM,
    SEQ_ROM_COPY,
    SEQ_RUN
  } seq_state_e;

  typedef enum logic [2:0] {
    CP_IDLE,
    CP_RD,
    CP_WAIT,
    CP_WR,
    CP_DONE
  } copy_state_e;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic int_rst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q[i] <= 1'b0;
        end else begin
          sync_q[i] <= (i == 0) ? 1'b1 : sync_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign int_rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   int_rst_n,
  input  strap_t strap_in,
  output strap_t strap_q
);

  logic   cap_en;
  strap_t strap_d;

  // track the pins while the internal reset is held, freeze afterwards
  always_comb begin
    cap_en  = ~int_rst_n;
    strap_d = strap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= '0;
    end else if (cap_en) begin
      strap_q <= strap_d;
    end
  end

endmodule

// File: rtl/boot_rom_copier.sv
module boot_rom_copier
  import boot_pkg::*;
#(
  parameter int              IMG_BYTES = 1024,
  parameter int              ROM_AW    = 32,
  parameter int              ROM_DW    = 16,
  parameter int              MEM_AW    = 12,
  parameter int              MEM_DW    = 32,
  parameter logic [ROM_AW-1:0] ROM_BASE = 32'h9000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rom16,
  input  logic              big_end,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_rvalid,
  input  logic [ROM_DW-1:0] rom_rdata,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [MEM_DW-1:0] wr_data,
  output logic              last_wr
);

  localparam int BPW      = MEM_DW / 8;
  localparam int WORDS    = IMG_BYTES / BPW;
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int OFF_W    = $clog2(IMG_BYTES);
  localparam int BEAT_W   = $clog2(BPW);
  localparam int ADDR_LSB = $clog2(BPW);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);
  localparam logic [BEAT_W-1:0] LAST_B8   = BEAT_W'(BPW - 1);
  localparam logic [BEAT_W-1:0] LAST_B16  = BEAT_W'(MEM_DW / ROM_DW - 1);

  copy_state_e       st_q, st_d;
  logic [WIDX_W-1:0] word_q, word_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [MEM_DW-1:0] acc_q, acc_d;
  logic              word_en, beat_en, off_en, acc_en;
  logic [BEAT_W-1:0] last_beat;
  logic [7:0]        rd_byte;

  assign last_beat = rom16 ? LAST_B16 : LAST_B8;
  assign rd_byte   = rom_rdata[7:0];

  // beat assembly: little-endian fills from the top and shifts down,
  // big-endian shifts up and fills from the bottom
  always_comb begin
    unique case ({rom16, big_end})
      2'b00:   acc_d = {rd_byte, acc_q[MEM_DW-1:8]};
      2'b01:   acc_d = {acc_q[MEM_DW-9:0], rd_byte};
      2'b10:   acc_d = {rom_rdata, acc_q[MEM_DW-1:ROM_DW]};
      default: acc_d = {acc_q[MEM_DW-ROM_DW-1:0], rom_rdata};
    endcase
  end

  always_comb begin
    st_d    = st_q;
    word_d  = word_q;
    beat_d  = beat_q;
    off_d   = off_q + (rom16 ? OFF_W'(ROM_DW / 8) : OFF_W'(1));
    word_en = 1'b0;
    beat_en = 1'b0;
    off_en  = 1'b0;
    acc_en  = 1'b0;
    unique case (st_q)
      CP_IDLE: if (go) st_d = CP_RD;
      CP_RD:   st_d = CP_WAIT;
      CP_WAIT: begin
        if (rom_rvalid) begin
          acc_en  = 1'b1;
          off_en  = 1'b1;
          beat_en = 1'b1;
          if (beat_q == last_beat) begin
            beat_d = '0;
            st_d   = CP_WR;
          end else begin
            beat_d = beat_q + 1'b1;
            st_d   = CP_RD;
          end
        end
      end
      CP_WR: begin
        if (word_q == LAST_WORD) begin
          st_d = CP_DONE;
        end else begin
          word_en = 1'b1;
          word_d  = word_q + 1'b1;
          st_d    = CP_RD;
        end
      end
      default: st_d = CP_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CP_IDLE;
      word_q <= '0;
      beat_q <= '0;
      off_q  <= '0;
      acc_q  <= '0;
    end else begin
      st_q <= st_d;
      if (word_en) word_q <= word_d;
      if (beat_en) beat_q <= beat_d;
      if (off_en)  off_q  <= off_d;
      if (acc_en)  acc_q  <= acc_d;
    end
  end

  assign rom_rd_en = (st_q == CP_RD);
  assign rom_addr  = ROM_BASE + ROM_AW'(off_q);
  assign wr_en     = (st_q == CP_WR);
  assign wr_addr   = MEM_AW'({word_q, {ADDR_LSB{1'b0}}});
  assign wr_data   = acc_q;
  assign last_wr   = wr_en && (word_q == LAST_WORD);

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  boot_mode_e mode,
  input  logic       host_start_wr,
  input  logic       dbg_release,
  input  logic       core_clr_start,
  input  logic       copy_last,
  output logic       core_stall,
  output logic       start_flag,
  output logic       core_irq,
  output logic       bkpt_armed,
  output logic       copy_go
);

  seq_state_e st_q, st_d;
  logic       flag_d, flag_en;
  logic       irq_d;
  logic       bkpt_d, bkpt_en;
  logic       host_ok;
  logic       running;

  assign running = (st_q == SEQ_RUN);
  assign host_ok = host_start_wr && (mode != MODE_ROM);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_HOLD: begin
        unique case (mode)
          MODE_DEBUG: st_d = SEQ_DBG_WAIT;
          MODE_ROM:   st_d = SEQ_ROM_COPY;
          default:    st_d = SEQ_HOST_WAIT;
        endcase
      end
      SEQ_HOST_WAIT: if (host_start_wr || start_flag) st_d = SEQ_RUN;
      SEQ_DBG_WAIT:  if (dbg_release) st_d = SEQ_DBG_ARM;
      SEQ_DBG_ARM:   st_d = SEQ_RUN;
      SEQ_ROM_COPY:  if (copy_last) st_d = SEQ_RUN;
      default:       st_d = SEQ_RUN;
    endcase
  end

  // start flag: set by host (not in ROM mode) or by the debug arm step,
  // cleared only by the running core; pulse only when set while running
  always_comb begin
    flag_d = start_flag;
    if (running && core_clr_start) flag_d = 1'b0;
    if (host_ok)                   flag_d = 1'b1;
    if (st_q == SEQ_DBG_ARM)       flag_d = 1'b1;
    flag_en = (flag_d != start_flag);
    irq_d   = running && host_ok && !start_flag;
    bkpt_d  = 1'b1;
    bkpt_en = (st_q == SEQ_DBG_WAIT) && dbg_release;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_HOLD;
      start_flag <= 1'b0;
      core_irq   <= 1'b0;
      bkpt_armed <= 1'b0;
    end else begin
      st_q     <= st_d;
      core_irq <= irq_d;
      if (flag_en) start_flag <= flag_d;
      if (bkpt_en) bkpt_armed <= bkpt_d;
    end
  end

  assign core_stall = ~running;
  assign copy_go    = (st_q == SEQ_ROM_COPY);

endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl
  import boot_pkg::*;
#(
  parameter int                IMG_BYTES   = 1024,
  parameter int                ROM_AW      = 32,
  parameter int                ROM_DW      = 16,
  parameter int                MEM_AW      = 12,
  parameter int                MEM_DW      = 32,
  parameter int                PC_W        = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ROM_AW-1:0] ROM_BASE    = 32'h9000_0000,
  parameter logic [PC_W-1:0]   START_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_boot_mode,
  input  logic              strap_rom16,
  input  logic              strap_big_end,
  input  logic              host_ctl_we,
  input  logic              host_ctl_start,
  input  logic              host_mem_we,
  input  logic [MEM_AW-1:0] host_mem_addr,
  input  logic [MEM_DW-1:0] host_mem_wdata,
  input  logic              dbg_release,
  input  logic              core_clr_start,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_rvalid,
  input  logic [ROM_DW-1:0] rom_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata,
  output logic              core_stall,
  output logic [PC_W-1:0]   core_start_addr,
  output logic              core_irq,
  output logic              start_flag,
  output logic              bkpt_armed,
  output logic              rom_done
);

  localparam int BPW = MEM_DW / 8;
  localparam logic [MEM_AW-1:0] LAST_WR_ADDR = MEM_AW'(IMG_BYTES - BPW);

  logic              int_rst_n;
  strap_t            strap_pins, strap_q;
  logic              copy_go;
  logic              cp_we;
  logic [MEM_AW-1:0] cp_addr;
  logic [MEM_DW-1:0] cp_data;
  logic              cp_last;
  logic              host_start_wr;

  assign strap_pins    = '{mode: boot_mode_e'(strap_boot_mode),
                           rom16: strap_rom16, big_end: strap_big_end};
  assign host_start_wr = host_ctl_we && host_ctl_start;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_rst_n (int_rst_n)
  );

  boot_strap_latch strap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_rst_n (int_rst_n),
    .strap_in  (strap_pins),
    .strap_q   (strap_q)
  );

  boot_seq_ctrl seq_i (
    .clk            (clk),
    .rst_n          (int_rst_n),
    .mode           (strap_q.mode),
    .host_start_wr  (host_start_wr),
    .dbg_release    (dbg_release),
    .core_clr_start (core_clr_start),
    .copy_last      (cp_last),
    .core_stall     (core_stall),
    .start_flag     (start_flag),
    .core_irq       (core_irq),
    .bkpt_armed     (bkpt_armed),
    .copy_go        (copy_go)
  );

  boot_rom_copier #(
    .IMG_BYTES (IMG_BYTES),
    .ROM_AW    (ROM_AW),
    .ROM_DW    (ROM_DW),
    .MEM_AW    (MEM_AW),
    .MEM_DW    (MEM_DW),
    .ROM_BASE  (ROM_BASE)
  ) copier_i (
    .clk        (clk),
    .rst_n      (int_rst_n),
    .go         (copy_go),
    .rom16      (strap_q.rom16),
    .big_end    (strap_q.big_end),
    .rom_rd_en  (rom_rd_en),
    .rom_addr   (rom_addr),
    .rom_rvalid (rom_rvalid),
    .rom_rdata  (rom_rdata),
    .wr_en      (cp_we),
    .wr_addr    (cp_addr),
    .wr_data    (cp_data),
    .last_wr    (cp_last)
  );

  // copy owns the write port while it runs; the host gets it otherwise
  always_comb begin
    if (copy_go) begin
      mem_we    = cp_we;
      mem_addr  = cp_addr;
      mem_wdata = cp_data;
    end else begin
      mem_we    = host_mem_we && int_rst_n;
      mem_addr  = host_mem_addr;
      mem_wdata = host_mem_wdata;
    end
  end

  assign rom_done        = cp_last && copy_go && (cp_addr == LAST_WR_ADDR);
  assign core_start_addr = START_ADDR;

endmodule

// File: rtl/boot_release_chk.sv
module boot_release_chk #(
  parameter int                MEM_AW    = 12,
  parameter logic [MEM_AW-1:0] LAST_ADDR = 12'h3FC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_stall,
  input logic              core_irq,
  input logic              start_flag,
  input logic              bkpt_armed,
  input logic              rom_rd_en,
  input logic              rom_done,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);

  // R1
  stall_in_reset_chk: assert property (@(posedge clk) !rst_n |-> core_stall);

  // R3
  stay_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_stall |=> !core_stall);

  // R4
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |=> !core_irq);

  // R4
  irq_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (!core_stall && start_flag));

  // R5
  bkpt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_armed |=> bkpt_armed);

  // R6
  rom_read_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> core_stall);

  // R9
  done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_done |-> (mem_we && mem_addr == LAST_ADDR && core_stall));

  // R9
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_done |=> !core_stall);

endmodule

bind boot_release_ctrl boot_release_chk #(
  .MEM_AW    (MEM_AW),
  .LAST_ADDR (LAST_WR_ADDR)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_stall (core_stall),
  .core_irq   (core_irq),
  .start_flag (start_flag),
  .bkpt_armed (bkpt_armed),
  .rom_rd_en  (rom_rd_en),
  .rom_done   (rom_done),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/boot_release_ctrl_tb_top.sv
module boot_release_ctrl_tb_top;

  localparam logic [31:0] ROM_BASE = 32'h9000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_boot_mode = 2'b00;
  logic        strap_rom16 = 1'b0;
  logic        strap_big_end = 1'b0;
  logic        host_ctl_we = 1'b0;
  logic        host_ctl_start = 1'b0;
  logic        host_mem_we = 1'b0;
  logic [11:0] host_mem_addr = '0;
  logic [31:0] host_mem_wdata = '0;
  logic        dbg_release = 1'b0;
  logic        core_clr_start = 1'b0;
  logic        rom_rd_en;
  logic [31:0] rom_addr;
  logic        rom_rvalid = 1'b0;
  logic [15:0] rom_rdata = '0;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        core_stall;
  logic [31:0] core_start_addr;
  logic        core_irq;
  logic        start_flag;
  logic        bkpt_armed;
  logic        rom_done;

  int n_chk = 0;
  int n_bad = 0;

  bit          cfg16 = 1'b0;
  bit          cfg_be = 1'b0;
  int          wr_cnt = 0;
  int          order_bad = 0;
  int          next_addr = 0;
  logic [31:0] cap [256];

  boot_release_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .strap_boot_mode (strap_boot_mode), .strap_rom16 (strap_rom16),
    .strap_big_end (strap_big_end),
    .host_ctl_we (host_ctl_we), .host_ctl_start (host_ctl_start),
    .host_mem_we (host_mem_we), .host_mem_addr (host_mem_addr),
    .host_mem_wdata (host_mem_wdata),
    .dbg_release (dbg_release), .core_clr_start (core_clr_start),
    .rom_rd_en (rom_rd_en), .rom_addr (rom_addr),
    .rom_rvalid (rom_rvalid), .rom_rdata (rom_rdata),
    .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .core_stall (core_stall), .core_start_addr (core_start_addr),
    .core_irq (core_irq), .start_flag (start_flag),
    .bkpt_armed (bkpt_armed), .rom_done (rom_done)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int o);
    return 8'(o * 7 + (o >> 8) * 29 + 90);
  endfunction

  function automatic logic [31:0] exp_word(input int w, input bit be);
    logic [7:0] b0, b1, b2, b3;
    b0 = rom_byte(4*w);   b1 = rom_byte(4*w+1);
    b2 = rom_byte(4*w+2); b3 = rom_byte(4*w+3);
    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  // ROM model: one-cycle read latency
  always @(posedge clk) begin
    int o;
    o = int'(rom_addr - ROM_BASE);
    rom_rvalid <= rom_rd_en;
    if (rom_rd_en) begin
      if (!cfg16)      rom_rdata <= {8'h00, rom_byte(o)};
      else if (!cfg_be) rom_rdata <= {rom_byte(o+1), rom_byte(o)};
      else             rom_rdata <= {rom_byte(o), rom_byte(o+1)};
    end
  end

  // internal memory write capture
  always @(posedge clk) begin
    if (mem_we) begin
      wr_cnt = wr_cnt + 1;
      if (int'(mem_addr) != next_addr) order_bad = order_bad + 1;
      next_addr = next_addr + 4;
      if (mem_addr[1:0] == 2'b00) cap[mem_addr[9:2]] = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // reset with straps; optional host start write in the sync window
  task automatic do_reset(input logic [1:0] mode, input bit r16, input bit be,
                          input bit poke);
    @(negedge clk);
    rst_n = 1'b0;
    strap_boot_mode = mode; strap_rom16 = r16; strap_big_end = be;
    cfg16 = r16; cfg_be = be;
    repeat (3) @(negedge clk);
    // R1 outputs while reset is low
    chk(core_stall == 1 && mem_we == 0 && rom_rd_en == 0 && rom_done == 0,
        "R1", "stall/we/rd/done in reset",
        {core_stall, mem_we, rom_rd_en, rom_done}, 4'b1000);
    chk(start_flag == 0 && core_irq == 0 && bkpt_armed == 0,
        "R1", "flag/irq/bkpt in reset", {start_flag, core_irq, bkpt_armed}, 0);
    wr_cnt = 0; order_bad = 0; next_addr = 0;
    rst_n = 1'b1;
    if (poke) begin
      host_ctl_we = 1'b1; host_ctl_start = 1'b1;
    end
    @(negedge clk);
    host_ctl_we = 1'b0; host_ctl_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_start();
    @(negedge clk);
    host_ctl_we = 1'b1; host_ctl_start = 1'b1;
    @(negedge clk);
    host_ctl_we = 1'b0; host_ctl_start = 1'b0;
  endtask

  task automatic dbg_pulse();
    @(negedge clk);
    dbg_release = 1'b1;
    @(negedge clk);
    dbg_release = 1'b0;
  endtask

  task automatic test_host(input logic [1:0] mode);
    do_reset(mode, 1'b0, 1'b0, 1'b1);
    chk(core_stall == 1 && start_flag == 0, "R3", "start write in reset ignored",
        {core_stall, start_flag}, 2'b10);
    repeat (10) @(negedge clk);
    chk(core_stall == 1, "R3", "host mode stays stalled", core_stall, 1);
    host_mem_we = 1'b1; host_mem_addr = 12'h040; host_mem_wdata = 32'hDEAD_BEEF;
    #1;
    chk(mem_we == 1 && mem_addr == 12'h040 && mem_wdata == 32'hDEAD_BEEF, "R11",
        "host memory write pass-through", mem_wdata, 32'hDEAD_BEEF);
    @(negedge clk);
    host_mem_we = 1'b0;
    dbg_pulse();
    @(negedge clk);
    chk(core_stall == 1 && bkpt_armed == 0, "R5", "debug release ignored in host mode",
        {core_stall, bkpt_armed}, 2'b10);
    host_start();
    chk(core_stall == 0 && start_flag == 1, "R3", "release after start write",
        {core_stall, start_flag}, 2'b01);
    chk(core_irq == 0, "R4", "no irq from releasing write", core_irq, 0);
    chk(core_start_addr == 0, "R3", "start address", core_start_addr, 0);
    host_start();
    chk(core_irq == 0, "R4", "start while flag set gives no irq", core_irq, 0);
    @(negedge clk);
    core_clr_start = 1'b1;
    @(negedge clk);
    core_clr_start = 1'b0;
    chk(start_flag == 0, "R4", "core clears flag", start_flag, 0);
    host_start();
    chk(core_irq == 1 && start_flag == 1, "R4", "irq pulse while running",
        {core_irq, start_flag}, 2'b11);
    @(negedge clk);
    chk(core_irq == 0, "R4", "irq lasts one cycle", core_irq, 0);
  endtask

  task automatic test_debug(input bit host_first);
    do_reset(2'b01, 1'b0, 1'b0, 1'b0);
    // R2: strap change after release must not switch to ROM boot
    strap_boot_mode = 2'b10;
    if (host_first) begin
      host_start();
      chk(start_flag == 1 && core_stall == 1, "R5", "host start sets flag, no release",
          {start_flag, core_stall}, 2'b11);
    end
    repeat (30) @(negedge clk);
    chk(wr_cnt == 0 && core_stall == 1, "R2", "late strap change ignored",
        wr_cnt, 0);
    dbg_pulse();
    chk(bkpt_armed == 1 && core_stall == 1, "R5", "breakpoint armed before release",
        {bkpt_armed, core_stall}, 2'b11);
    @(negedge clk);
    chk(core_stall == 0 && start_flag == 1 && bkpt_armed == 1, "R5",
        "debug release", {core_stall, start_flag, bkpt_armed}, 3'b011);
  endtask

  task automatic test_rom(input bit r16, input bit be);
    int guard;
    int mism;
    do_reset(2'b10, r16, be, 1'b0);
    // R2: flip straps after release
    strap_boot_mode = 2'b00; strap_rom16 = ~r16; strap_big_end = ~be;
    repeat (20) @(negedge clk);
    host_start();
    dbg_pulse();
    chk(start_flag == 0 && bkpt_armed == 0 && core_stall == 1, "R10",
        "requests ignored during copy", {start_flag, bkpt_armed, core_stall}, 3'b001);
    guard = 0;
    while (!rom_done && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
    chk(rom_done == 1 && mem_we == 1 && mem_addr == 12'h3FC && core_stall == 1, "R9",
        "done on last write", {rom_done, mem_we, core_stall, mem_addr}, {3'b111, 12'h3FC});
    @(negedge clk);
    chk(core_stall == 0, "R9", "stall drops after done", core_stall, 0);
    chk(wr_cnt == 256 && order_bad == 0, "R6", "word count and address order",
        wr_cnt, 256);
    mism = 0;
    for (int w = 0; w < 256; w++) begin
      if (cap[w] !== exp_word(w, be)) begin
        if (mism == 0)
          chk(1'b0, r16 ? "R8" : "R7", "first mismatched word", cap[w], exp_word(w, be));
        mism++;
      end
    end
    chk(mism == 0, r16 ? "R8" : "R7", "packed image words (R2 straps held)", mism, 0);
    host_start();
    dbg_pulse();
    chk(start_flag == 0 && core_irq == 0 && bkpt_armed == 0, "R10",
        "requests ignored after copy", {start_flag, core_irq, bkpt_armed}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    test_host(2'b00);
    test_host(2'b11);
    test_debug(1'b1);
    test_debug(1'b0);
    test_rom(1'b0, 1'b0);
    test_rom(1'b0, 1'b1);
    test_rom(1'b1, 1'b0);
    test_rom(1'b1, 1'b1);
    summary();
    $finish;
  end

endmodule